// File: doc/BRIEF.md
# Two-Way Storing Bus Transceiver

This block connects two 18-bit buses, called A and B, with one independent path for each direction. Each path has a storage cell with three modes. In pass mode the cell follows its source bus. In hold mode it keeps its value. In capture mode it takes a new value when the path's own strobe falls. Each path also has a drive enable. When the enable is high, the far port presents the path's value. When it is low, the far port is released.

The block is written for a synchronous chip, so there are no internal tri-state nets. Each port is modelled as a data vector plus a per-bit drive-enable vector, and a pad ring or bus fabric turns these into real three-state drivers.

Each path's strobe is sampled on the system clock, and a falling edge is detected between two consecutive samples. Pass mode is combinational from the source input to the far port. A synchronous reset clears both stored values and both strobe samples.

Top module: `dual_path_xcvr`

## Requirements
- R1: Each direction carries a data word of `W` bits. The default is 18, and the bus ports are that wide.
- R2: While a path's pass control is high, its destination data output equals its source input in the same cycle, and it follows any change of the source without waiting for a clock edge.
- R3: While pass is low and the path's strobe is not falling, the destination data stays unchanged even when the source changes.
- R4: With pass low, if the strobe is sampled 1 at one system clock edge and 0 at the next, the source value present at that second edge is stored. The new value appears on the destination output right after that edge.
- R5: With pass low, a rising strobe (sampled 0 and then 1) leaves the stored value unchanged.
- R6: When pass drops from high to low, the destination keeps the source value that was present at the last clock edge at which pass was still high.
- R7: When a path's drive enable is high, every bit of the destination drive vector is 1 and the destination data shows the path's value. When the enable is low, the drive vector is all 0 and the destination data reads all 0. Storage is unaffected in both cases.
- R8: The B-to-A path (source `b_in`, destination `a_out`/`a_drv`) behaves exactly like the A-to-B path, using only its own three controls.
- R9: A synchronous reset (`rst` high at a clock edge) clears both stored values to zero. It also clears both strobe samples to zero, so a strobe held high across reset is not treated as a falling edge.
- R10: The two paths are independent. Both can drive at the same time with different data, and activity on one path's controls never changes the other path's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Value seen on bus A (source of the A-to-B path) |
| b_in | input | 18 | Value seen on bus B (source of the B-to-A path) |
| a2b_pass | input | 1 | A-to-B pass control: high = transparent |
| a2b_tick | input | 1 | A-to-B capture strobe; falling edge stores |
| a2b_en | input | 1 | A-to-B drive enable for bus B, active high |
| b2a_pass | input | 1 | B-to-A pass control: high = transparent |
| b2a_tick | input | 1 | B-to-A capture strobe; falling edge stores |
| b2a_en | input | 1 | B-to-A drive enable for bus A, active high |
| a_out | output | 18 | Data presented toward bus A |
| a_drv | output | 18 | Per-bit drive enable for bus A |
| b_out | output | 18 | Data presented toward bus B |
| b_drv | output | 18 | Per-bit drive enable for bus B |

## Verification
A stored value that is wrong shows up on the destination data as soon as that path leaves pass mode with its drive enabled. For example, a missed or spurious capture changes the output right after the clock edge at which the strobe sample goes low, or right after a rising sample. A wrong strobe sample left over from reset, or leakage between the two paths, is also visible within one system clock edge. The checks therefore look at the outputs immediately after each edge and again after the source has been changed while storage should hold, so a hold that fails is told apart from a capture that happens late.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    M_HOLD    = 2'd0,
    M_PASS    = 2'd1,
    M_CAPTURE = 2'd2
  } cell_mode_e;

  // Pass control dominates. A sampled falling strobe captures; otherwise hold.
  function automatic cell_mode_e pick_mode(input logic pass, input logic fall);
    if (pass)      return M_PASS;
    else if (fall) return M_CAPTURE;
    else           return M_HOLD;
  endfunction

  // A released port reads as zero, so it never carries stale data.
  function automatic logic gate_bit(input logic en, input logic d);
    return en & d;
  endfunction

endpackage

// File: rtl/edge_sampler.sv
module edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= tick;
  end

  assign fall = prev_q & ~tick;
  assign rise = ~prev_q & tick;

  // R9: after reset the sample is low, so a held-high strobe shows no fall
  a_r9_no_fall_after_reset: assert property (@(posedge clk)
    rst |=> !fall);
endmodule

// File: rtl/store_cell.sv
module store_cell
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         pass,
  input  logic         fall,
  input  logic         rise,
  output logic [W-1:0] q
);
  cell_mode_e mode;
  logic [W-1:0] store_q;

  assign mode = pick_mode(pass, fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else begin
      unique case (mode)
        M_PASS, M_CAPTURE: store_q <= din;
        M_HOLD:            store_q <= store_q;
        default:           store_q <= store_q;
      endcase
    end
  end

  // Transparent bypass gives zero latency in pass mode.
  assign q = pass ? din : store_q;

  a_r3_hold_steady: assert property (@(posedge clk) disable iff (rst)
    (!pass && !fall) |=> $stable(store_q));

  a_r4_capture_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!pass && fall) |=> (store_q == $past(din)));

  a_r5_rise_ignored: assert property (@(posedge clk) disable iff (rst)
    (!pass && rise) |=> $stable(store_q));

  a_r6_keep_last_pass: assert property (@(posedge clk) disable iff (rst)
    (pass ##1 !pass) |-> (q == $past(din)));

  a_r9_clear: assert property (@(posedge clk)
    rst |=> (store_q == '0));
endmodule

// File: rtl/port_drive.sv
module port_drive
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] val,
  output logic [W-1:0] data,
  output logic [W-1:0] drv
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign data[i] = gate_bit(en, val[i]);
    assign drv[i]  = en;
  end

  a_r7_released_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |-> (drv == '0 && data == '0));

  a_r7_driven_full: assert property (@(posedge clk) disable iff (rst)
    en |-> ($countones(drv) == W && data == val));
endmodule

// File: rtl/dir_path.sv
module dir_path #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         pass,
  input  logic         tick,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic [W-1:0] drv
);
  logic         fall_w;
  logic         rise_w;
  logic [W-1:0] cell_q;

  edge_sampler u_edge (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .fall (fall_w),
    .rise (rise_w)
  );

  store_cell #(.W(W)) u_cell (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .pass (pass),
    .fall (fall_w),
    .rise (rise_w),
    .q    (cell_q)
  );

  port_drive #(.W(W)) u_drv (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .val  (cell_q),
    .data (dout),
    .drv  (drv)
  );
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a2b_pass,
  input  logic         a2b_tick,
  input  logic         a2b_en,
  input  logic         b2a_pass,
  input  logic         b2a_tick,
  input  logic         b2a_en,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv
);
  localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

  logic [NDIR-1:0][W-1:0] src_v, dst_v, drv_v;
  logic [NDIR-1:0]        pass_v, tick_v, en_v;

  assign src_v  = {b_in, a_in};
  assign pass_v = {b2a_pass, a2b_pass};
  assign tick_v = {b2a_tick, a2b_tick};
  assign en_v   = {b2a_en, a2b_en};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    dir_path #(.W(W)) u_path (
      .clk  (clk),
      .rst  (rst),
      .din  (src_v[d]),
      .pass (pass_v[d]),
      .tick (tick_v[d]),
      .en   (en_v[d]),
      .dout (dst_v[d]),
      .drv  (drv_v[d])
    );
  end

  assign b_out = dst_v[0];
  assign b_drv = drv_v[0];
  assign a_out = dst_v[1];
  assign a_drv = drv_v[1];

  // R10: with B-to-A idle (holding, enabled), A-to-B activity leaves bus A steady
  a_r10_paths_isolated: assert property (@(posedge clk) disable iff (rst)
    (!b2a_pass && b2a_en && !(($past(b2a_tick)) && !b2a_tick)) |=> $stable(a_out) || !b2a_en || b2a_pass);
endmodule

// File: tb/sim_dual_path_xcvr.sv
module sim_dual_path_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic         a2b_pass, a2b_tick, a2b_en;
  logic         b2a_pass, b2a_tick, b2a_en;
  logic [W-1:0] a_out, a_drv, b_out, b_drv;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_path_xcvr #(.W(W)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .a2b_pass(a2b_pass), .a2b_tick(a2b_tick), .a2b_en(a2b_en),
    .b2a_pass(b2a_pass), .b2a_tick(b2a_tick), .b2a_en(b2a_en),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a_in = '1; b_in = '1;
    a2b_pass = 1'b0; a2b_tick = 1'b0; a2b_en = 1'b1;
    b2a_pass = 1'b0; b2a_tick = 1'b0; b2a_en = 1'b1;
    step(); step();
    rst = 1'b0;
    #1;
    chk("R9 b_out after reset", b_out, '0);
    chk("R9 a_out after reset", a_out, '0);
    chk("R1 width", W'($bits(b_out)), W'(18));
  endtask

  task automatic t_ab_pass_and_drop();
    a2b_pass = 1'b1;
    a_in = 18'h2A5C3; #1;
    chk("R2 pass same cycle", b_out, 18'h2A5C3);
    a_in = 18'h1F00F; #1;
    chk("R2 pass follows change", b_out, 18'h1F00F);
    step();
    a2b_pass = 1'b0; #1;
    chk("R6 keep last pass value", b_out, 18'h1F00F);
    a_in = 18'h00777; step();
    chk("R3 hold ignores source", b_out, 18'h1F00F);
  endtask

  task automatic t_ab_clocked();
    a2b_tick = 1'b1; a_in = 18'h13579; step();
    chk("R5 rising strobe no change", b_out, 18'h1F00F);
    a2b_tick = 1'b0; a_in = 18'h3C3C3; step();
    chk("R4 falling strobe captures", b_out, 18'h3C3C3);
    a_in = 18'h0AAAA; step();
    chk("R3 strobe low steady holds", b_out, 18'h3C3C3);
  endtask

  task automatic t_ab_enable();
    a2b_en = 1'b0; #1;
    chk("R7 released drive", b_drv, '0);
    chk("R7 released data", b_out, '0);
    step();
    a2b_en = 1'b1; #1;
    chk("R7 driven all bits", b_drv, '1);
    chk("R7 driven data kept", b_out, 18'h3C3C3);
  endtask

  task automatic t_ba_path();
    b2a_pass = 1'b1; b_in = 18'h24680; #1;
    chk("R8 B-to-A pass", a_out, 18'h24680);
    step();
    b2a_pass = 1'b0; b_in = 18'h11111; step();
    chk("R8 B-to-A hold", a_out, 18'h24680);
    b2a_tick = 1'b1; step();
    b2a_tick = 1'b0; b_in = 18'h2DEAD; step();
    chk("R8 B-to-A capture", a_out, 18'h2DEAD);
    b2a_en = 1'b0; #1;
    chk("R8 B-to-A release", a_drv, '0);
    b2a_en = 1'b1; #1;
  endtask

  task automatic t_both();
    a_in = 18'h155AA; b_in = 18'h2AA55;
    a2b_tick = 1'b1; b2a_tick = 1'b1; step();
    a2b_tick = 1'b0; b2a_tick = 1'b0; step();
    chk("R10 A-to-B value", b_out, 18'h155AA);
    chk("R10 B-to-A value", a_out, 18'h2AA55);
    chk("R10 both drive", a_drv & b_drv, '1);
    a_in = 18'h0F0F0; b_in = 18'h00001;
    a2b_tick = 1'b1; step();
    a2b_tick = 1'b0; step();
    chk("R10 A-to-B recaptured", b_out, 18'h0F0F0);
    chk("R10 B-to-A untouched", a_out, 18'h2AA55);
  endtask

  task automatic t_reset_strobe_high();
    a2b_tick = 1'b1; rst = 1'b1; step();
    rst = 1'b0; a2b_tick = 1'b0; a_in = 18'h3FFFF; step();
    chk("R9 no capture from pre-reset strobe", b_out, '0);
    chk("R9 other path cleared", a_out, '0);
  endtask

  initial begin
    t_reset();
    t_ab_pass_and_drop();
    t_ab_clocked();
    t_ab_enable();
    t_ba_path();
    t_both();
    t_reset_strobe_high();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule